// File: doc/BRIEF.md
# Deferred-Fault Speculative Load Checker

This block sits beside the load pipeline. It looks at a speculative load before the load goes to memory. It forms the effective address from a base register value and one of two offsets: an index register value or a sign-extended immediate. It then checks that the address is aligned for the access size, and for wide accesses it also checks that the destination register number is aligned. The block never raises an exception. It records each fault as a per-register "not-excepted" (NE) poison flag, kept in one of two 64-entry banks: one bank for the integer register file and one for the float register file.

Poison also spreads from sources to the destination. When a load has no fault of its own but one of its source registers is already poisoned, the block poisons the destination and cancels the memory access.

An optional logging mode can be switched on through a control word. In this mode each checked load claims the lowest free status slot and produces a status word and an address word for that slot. The slot storage itself is outside the block and reports which slots are in use through a busy vector. Every result appears one clock cycle after the request strobe.

Top module: `nel_fault_check`

## Requirements
- R1: The reported address is base_val + index_val when use_index is 1, and base_val + sign-extended imm otherwise, computed modulo 2^32.
- R2: Size codes: 0 byte, 1 halfword, 2 word, 3 doubleword, 4 quadword; codes 5 to 7 behave as byte. An address-misalignment fault (fault_addr) is raised when the low 0/1/2/3/4 address bits for those sizes are not all zero.
- R3: A register-misalignment fault (fault_reg) is raised for a doubleword with an odd dest_reg, or for a quadword whose dest_reg is not a multiple of 4; other sizes never raise it.
- R4: On either fault, the dest_reg flag is set in the bank chosen by is_float (0 integer, 1 float), and load_go is 1.
- R5: With no fault, if the selected bank flags base_reg, or flags index_reg when use_index is 1, then the dest_reg flag is set and load_go is 0.
- R6: With no fault and no poisoned source, the dest_reg flag is cleared and load_go is 1. The other bank is never changed.
- R7: Logging is active only when ctl_valid and ctl_log_en are both 1. log_we pulses only for an active request that found a free slot.
- R8: The slot chosen is the lowest index i with slot_busy[i]=0 and i < ctl_slot_count. Slots at or above the parameter NSLOT=4 do not exist.
- R9: log_status bit 0 is valid(1), bit 1 is address-valid(1), bits 7:2 are dest_reg, bits 10:8 are the size code, bits 12:11 are the slot index, bit 13 is is_float, bit 14 is the register-misalignment code, and bit 15 is the address-misalignment code. log_addr is the effective address.
- R10: An active logging request with no free slot sets no_slot_err. This flag stays set until reset, and no slot write happens for that request.
- R11: After reset, every output and both banks are zero. rsp_valid is 1 for exactly the cycle after each request strobe, and every result is registered into that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per load |
| base_reg | input | 6 | Base register number |
| base_val | input | 32 | Base register value |
| use_index | input | 1 | Use the index register instead of the immediate |
| index_reg | input | 6 | Index register number |
| index_val | input | 32 | Index register value |
| imm | input | 12 | Signed immediate offset |
| dest_reg | input | 6 | Destination register number |
| acc_size | input | 3 | Access size code |
| is_float | input | 1 | 1 when the destination is in the float file |
| ctl_valid | input | 1 | Control word valid |
| ctl_log_en | input | 1 | Logging enable |
| ctl_slot_count | input | 3 | Number of implemented slots |
| slot_busy | input | 4 | Slot in-use bits |
| rsp_valid | output | 1 | Result valid |
| load_go | output | 1 | Perform the memory access |
| addr_out | output | 32 | Effective address |
| fault_addr | output | 1 | Address-misalignment fault |
| fault_reg | output | 1 | Register-misalignment fault |
| gr_ne | output | 64 | Integer NE flag bank |
| fr_ne | output | 64 | Float NE flag bank |
| log_we | output | 1 | Slot write strobe |
| log_idx | output | 2 | Slot being written |
| log_status | output | 16 | Status word for the slot |
| log_addr | output | 32 | Address word for the slot |
| no_slot_err | output | 1 | Sticky no-free-slot error |

## Verification
The address and alignment logic is swept over every size code, all sixteen low address nibbles and four destination numbers, with both banks used in turn. This sweep separates the address-misalignment and register-misalignment faults, and shows that a faulting load still goes ahead. Short sequences then poison a register and use it as the base or as the index. These sequences tell propagation apart from an own fault, and show that an unused index register is ignored. A further sweep covers every busy pattern against every slot count and every combination of the control bits. This sweep exercises the priority search, the status word layout and the sticky error.

// File: rtl/nel_pkg.sv
package nel_pkg;
    localparam int ADDR_W  = 32;
    localparam int REG_W   = 6;
    localparam int NREG    = 1 << REG_W;
    localparam int IMM_W   = 12;
    localparam int NSLOT   = 4;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int CNT_W   = SLOT_W + 1;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_QUAD = 3'd4
    } acc_size_e;

    typedef struct packed {
        logic              ec;
        logic              rec;
        logic              flt;
        logic [SLOT_W-1:0] slot;
        logic [2:0]        size;
        logic [REG_W-1:0]  dest;
        logic              av;
        logic              v;
    } slot_status_t;

    localparam int STAT_W = $bits(slot_status_t);

    function automatic logic [ADDR_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(ADDR_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/nel_addr_check.sv
module nel_addr_check
    import nel_pkg::*;
(
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              use_index,
    input  logic [IMM_W-1:0]  imm,
    input  logic [REG_W-1:0]  dest_reg,
    input  logic [2:0]        acc_size,
    output logic [ADDR_W-1:0] ea,
    output logic              ec,
    output logic              rec
);
    always_comb begin
        ea  = base_val + (use_index ? index_val : sext_imm(imm));
        ec  = 1'b0;
        rec = 1'b0;
        case (acc_size)
            SZ_HALF: ec = ea[0];
            SZ_WORD: ec = |ea[1:0];
            SZ_DBL: begin
                ec  = |ea[2:0];
                rec = dest_reg[0];
            end
            SZ_QUAD: begin
                ec  = |ea[3:0];
                rec = |dest_reg[1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nel_slot_pick.sv
module nel_slot_pick
    import nel_pkg::*;
(
    input  logic [NSLOT-1:0]  busy,
    input  logic [CNT_W-1:0]  count,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    logic [NSLOT-1:0] avail;

    for (genvar g = 0; g < NSLOT; g++) begin : g_avail
        assign avail[g] = !busy[g] && (CNT_W'(g) < count);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end

    // R8
    always_comb begin
        if (found) begin
            pick_free_chk: assert (!busy[idx] && ({1'b0, idx} < count));
        end
    end
endmodule

// File: rtl/nel_ne_bank.sv
module nel_ne_bank
    import nel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] idx,
    output logic [NREG-1:0]  flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (set_en) begin
            flags[idx] <= 1'b1;
        end else if (clr_en) begin
            flags[idx] <= 1'b0;
        end
    end

    // R4
    ne_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> flags[$past(idx)]);

    // R6
    ne_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> !flags[$past(idx)]);
endmodule

// File: rtl/nel_fault_check.sv
module nel_fault_check
    import nel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [REG_W-1:0]       base_reg,
    input  logic [ADDR_W-1:0]      base_val,
    input  logic                   use_index,
    input  logic [REG_W-1:0]       index_reg,
    input  logic [ADDR_W-1:0]      index_val,
    input  logic [IMM_W-1:0]       imm,
    input  logic [REG_W-1:0]       dest_reg,
    input  logic [2:0]             acc_size,
    input  logic                   is_float,
    input  logic                   ctl_valid,
    input  logic                   ctl_log_en,
    input  logic [CNT_W-1:0]       ctl_slot_count,
    input  logic [NSLOT-1:0]       slot_busy,
    output logic                   rsp_valid,
    output logic                   load_go,
    output logic [ADDR_W-1:0]      addr_out,
    output logic                   fault_addr,
    output logic                   fault_reg,
    output logic [NREG-1:0]        gr_ne,
    output logic [NREG-1:0]        fr_ne,
    output logic                   log_we,
    output logic [SLOT_W-1:0]      log_idx,
    output logic [STAT_W-1:0]      log_status,
    output logic [ADDR_W-1:0]      log_addr,
    output logic                   no_slot_err
);
    logic [ADDR_W-1:0] ea;
    logic              ec, rec, any_fault, poisoned, log_on, found;
    logic [SLOT_W-1:0] pick;
    logic [NREG-1:0]   bank_q [2];
    logic [NREG-1:0]   sel_bank;
    slot_status_t      stat;

    nel_addr_check u_addr (
        .base_val (base_val),
        .index_val(index_val),
        .use_index(use_index),
        .imm      (imm),
        .dest_reg (dest_reg),
        .acc_size (acc_size),
        .ea       (ea),
        .ec       (ec),
        .rec      (rec)
    );

    nel_slot_pick u_pick (
        .busy (slot_busy),
        .count(ctl_slot_count),
        .found(found),
        .idx  (pick)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic hit;
        assign hit = req_valid && (is_float == b[0]);
        nel_ne_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .set_en(hit && (any_fault || poisoned)),
            .clr_en(hit && !any_fault && !poisoned),
            .idx   (dest_reg),
            .flags (bank_q[b])
        );
    end

    assign gr_ne = bank_q[0];
    assign fr_ne = bank_q[1];

    always_comb begin
        sel_bank  = is_float ? bank_q[1] : bank_q[0];
        any_fault = ec || rec;
        poisoned  = !any_fault &&
                    (sel_bank[base_reg] || (use_index && sel_bank[index_reg]));
        log_on    = ctl_valid && ctl_log_en;
        stat      = '{ec: ec, rec: rec, flt: is_float, slot: pick,
                      size: acc_size, dest: dest_reg, av: 1'b1, v: 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            load_go     <= 1'b0;
            addr_out    <= '0;
            fault_addr  <= 1'b0;
            fault_reg   <= 1'b0;
            log_we      <= 1'b0;
            log_idx     <= '0;
            log_status  <= '0;
            log_addr    <= '0;
            no_slot_err <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            load_go   <= req_valid && !poisoned;
            log_we    <= req_valid && log_on && found;
            if (req_valid) begin
                addr_out   <= ea;
                fault_addr <= ec;
                fault_reg  <= rec;
                if (log_on && found) begin
                    log_idx    <= pick;
                    log_status <= stat;
                    log_addr   <= ea;
                end
                if (log_on && !found) begin
                    no_slot_err <= 1'b1;
                end
            end
        end
    end

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R7
    log_we_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        log_we |-> rsp_valid);

    // R5
    suppress_only_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !load_go) |-> !(fault_addr || fault_reg));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        no_slot_err |=> no_slot_err);

    // R4
    go_only_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        load_go |-> rsp_valid);
endmodule

// File: tb/nel_fault_check_test.sv
`timescale 1ns/1ps
module nel_fault_check_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  base_reg = '0, index_reg = '0, dest_reg = '0;
    logic [31:0] base_val = '0, index_val = '0;
    logic        use_index = 1'b0, is_float = 1'b0;
    logic [11:0] imm = '0;
    logic [2:0]  acc_size = '0, ctl_slot_count = '0;
    logic        ctl_valid = 1'b0, ctl_log_en = 1'b0;
    logic [3:0]  slot_busy = '0;
    logic        rsp_valid, load_go, fault_addr, fault_reg, log_we, no_slot_err;
    logic [31:0] addr_out, log_addr;
    logic [63:0] gr_ne, fr_ne;
    logic [1:0]  log_idx;
    logic [15:0] log_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] m_ne [2];
    logic        m_err = 1'b0;

    always #10 clk = ~clk;

    nel_fault_check uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .base_reg(base_reg), .base_val(base_val), .use_index(use_index),
        .index_reg(index_reg), .index_val(index_val), .imm(imm),
        .dest_reg(dest_reg), .acc_size(acc_size), .is_float(is_float),
        .ctl_valid(ctl_valid), .ctl_log_en(ctl_log_en),
        .ctl_slot_count(ctl_slot_count), .slot_busy(slot_busy),
        .rsp_valid(rsp_valid), .load_go(load_go), .addr_out(addr_out),
        .fault_addr(fault_addr), .fault_reg(fault_reg), .gr_ne(gr_ne),
        .fr_ne(fr_ne), .log_we(log_we), .log_idx(log_idx),
        .log_status(log_status), .log_addr(log_addr), .no_slot_err(no_slot_err)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [5:0] b, input logic [31:0] bv,
                       input logic ui, input logic [5:0] x, input logic [31:0] xv,
                       input logic [11:0] im, input logic [5:0] d,
                       input logic [2:0] sz, input logic fl, input logic cv,
                       input logic cl, input logic [2:0] cc, input logic [3:0] bz);
        logic [31:0] ea;
        logic e_ec, e_rec, pois, act, fnd, go;
        logic [1:0] pk;
        logic [15:0] st;
        string tg;
        ea = bv + (ui ? xv : {{20{im[11]}}, im});
        e_ec = 1'b0; e_rec = 1'b0;
        case (sz)
            3'd1: e_ec = ea[0] != 1'b0;
            3'd2: e_ec = ea[1:0] != 2'd0;
            3'd3: begin e_ec = ea[2:0] != 3'd0; e_rec = d[0]; end
            3'd4: begin e_ec = ea[3:0] != 4'd0; e_rec = d[1:0] != 2'd0; end
            default: ;
        endcase
        pois = !(e_ec || e_rec) && (m_ne[fl][b] || (ui && m_ne[fl][x]));
        go = !pois;
        act = cv && cl;
        fnd = 1'b0; pk = 2'd0;
        for (int i = 3; i >= 0; i--)
            if (!bz[i] && i < int'(cc)) begin fnd = 1'b1; pk = 2'(i); end
        st = {e_ec, e_rec, fl, pk, sz, d, 1'b1, 1'b1};
        if (e_ec || e_rec) begin m_ne[fl][d] = 1'b1; tg = "R4"; end
        else if (pois) begin m_ne[fl][d] = 1'b1; tg = "R5"; end
        else begin m_ne[fl][d] = 1'b0; tg = "R6"; end
        if (act && !fnd) m_err = 1'b1;

        @(negedge clk);
        base_reg = b; base_val = bv; use_index = ui; index_reg = x;
        index_val = xv; imm = im; dest_reg = d; acc_size = sz; is_float = fl;
        ctl_valid = cv; ctl_log_en = cl; ctl_slot_count = cc; slot_busy = bz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R11 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(addr_out === ea, "R1 addr", 64'(addr_out), 64'(ea));
        chk(fault_addr === e_ec, "R2 fault_addr", 64'(fault_addr), 64'(e_ec));
        chk(fault_reg === e_rec, "R3 fault_reg", 64'(fault_reg), 64'(e_rec));
        chk(load_go === go, {tg, " load_go"}, 64'(load_go), 64'(go));
        chk(gr_ne === m_ne[0], {tg, " gr_ne"}, gr_ne, m_ne[0]);
        chk(fr_ne === m_ne[1], {tg, " fr_ne"}, fr_ne, m_ne[1]);
        chk(log_we === (act && fnd), "R7 log_we", 64'(log_we), 64'(act && fnd));
        if (act && fnd) begin
            chk(log_idx === pk, "R8 log_idx", 64'(log_idx), 64'(pk));
            chk(log_status === st, "R9 log_status", 64'(log_status), 64'(st));
            chk(log_addr === ea, "R9 log_addr", 64'(log_addr), 64'(ea));
        end
        chk(no_slot_err === m_err, "R10 no_slot_err", 64'(no_slot_err), 64'(m_err));
    endtask

    initial begin
        m_ne[0] = '0; m_ne[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk({rsp_valid, load_go, fault_addr, fault_reg, log_we, no_slot_err} === 6'd0,
            "R11 reset flags", 64'({rsp_valid, load_go, fault_addr, fault_reg, log_we, no_slot_err}), 64'd0);
        chk(gr_ne === 64'd0 && fr_ne === 64'd0, "R11 reset banks", gr_ne | fr_ne, 64'd0);
        chk(addr_out === 32'd0 && log_status === 16'd0, "R11 reset data",
            64'(addr_out) | 64'(log_status), 64'd0);

        // R2/R3/R4/R6 sweep of sizes, low address bits, destinations, banks
        for (int sz = 0; sz < 8; sz++)
            for (int lo = 0; lo < 16; lo++)
                for (int d = 0; d < 4; d++)
                    run(6'd1, 32'h1000 + 32'(lo), 1'b0, 6'd2, 32'd0, 12'd0,
                        6'(8 + d), 3'(sz), 1'(lo + d), 1'b0, 1'b0, 3'd0, 4'd0);

        // R1 negative immediate and index path with wrap
        run(6'd3, 32'h0000_0010, 1'b0, 6'd4, 32'd0, 12'hFF0, 6'd20, 3'd2, 1'b0, 0, 0, 0, 0);
        run(6'd3, 32'hFFFF_FFF0, 1'b1, 6'd4, 32'h20, 12'h7FF, 6'd21, 3'd4, 1'b0, 0, 0, 0, 0);

        // R5 poison via base: fault on r30 then use it as base
        run(6'd1, 32'h1, 1'b0, 6'd0, 0, 12'd0, 6'd30, 3'd2, 1'b0, 0, 0, 0, 0);
        run(6'd30, 32'h100, 1'b0, 6'd0, 0, 12'd0, 6'd31, 3'd2, 1'b0, 0, 0, 0, 0);
        // R5 poison via index, and index ignored when not used
        run(6'd1, 32'h100, 1'b1, 6'd30, 32'h4, 12'd0, 6'd32, 3'd2, 1'b0, 0, 0, 0, 0);
        run(6'd1, 32'h100, 1'b0, 6'd30, 32'h4, 12'd0, 6'd33, 3'd2, 1'b0, 0, 0, 0, 0);
        // R6 other bank not affected by poison in integer bank
        run(6'd30, 32'h100, 1'b0, 6'd0, 0, 12'd0, 6'd31, 3'd2, 1'b1, 0, 0, 0, 0);
        // R4 own fault wins over poison: load still performed
        run(6'd30, 32'h101, 1'b0, 6'd0, 0, 12'd0, 6'd34, 3'd1, 1'b0, 0, 0, 0, 0);
        // R6 clean load clears poison
        run(6'd1, 32'h100, 1'b0, 6'd0, 0, 12'd0, 6'd30, 3'd2, 1'b0, 0, 0, 0, 0);

        // R7 control bit combinations
        for (int c = 0; c < 4; c++)
            run(6'd1, 32'h200, 1'b0, 6'd0, 0, 12'd0, 6'd40, 3'd3, 1'b1,
                c[0], c[1], 3'd4, 4'd0);

        // R8/R9/R10 slot search over busy patterns and counts
        for (int cc = 0; cc < 8; cc++)
            for (int bz = 0; bz < 16; bz++)
                run(6'd1, 32'h300 + 32'(bz), 1'b0, 6'd0, 0, 12'd0, 6'(bz + cc),
                    3'(bz % 5), 1'(cc), 1'b1, 1'b1, 3'(cc), 4'(bz));

        // R10 stays set after a successful log
        run(6'd1, 32'h400, 1'b0, 6'd0, 0, 12'd0, 6'd50, 3'd0, 1'b0, 1, 1, 3'd4, 4'd0);

        // R11 rsp_valid drops after one cycle
        @(negedge clk);
        chk(rsp_valid === 1'b0 && log_we === 1'b0, "R11 pulse end",
            64'({rsp_valid, log_we}), 64'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule